// File: doc/BRIEF.md
# Serial Transceiver with Hardware Handshake and Switchable Byte Queues

This block moves bytes between a parallel register port and a pair of asynchronous serial lines. A frame is one low start bit, eight data bits sent least-significant bit first, and one high stop bit. Each bit lasts a fixed number of clock cycles, set by a parameter. The serial output idles high. The receiver watches the serial input for a falling edge and samples each bit at its midpoint.

Flow control runs over a pair of handshake lines. The hold-off output goes high when this side cannot take more data: its receive storage is full, or reception is disabled. The peer's hold-off output is wired to this block's hold-off input. When handshake checking is enabled, a new byte is launched only while that input is low. The check is made at the start of each byte, so a byte already on the line always completes.

A run-time mode input picks the storage. In queue mode, four-byte queues buffer each direction. In direct mode, a write loads the transmitter's single holding byte, and a read returns the last received byte. The data port is 16 bits wide, but only its low byte carries data.

Top module: `uart_fc_core`

## Requirements
- R1: After reset, `rd_data` is 0x0000, `txd` is high, `frame_err` is low and `tx_active` is low.
- R2: A frame on `txd` is one low start bit, then `wr_data[0]` through `wr_data[7]` in that order, then exactly one high stop bit, each lasting CLKS_PER_BIT cycles. With an idle transmitter, the start bit appears on `txd` after the second rising edge that follows the write strobe.
- R3: While `cts_en` is 1, a byte is launched only when `peer_hold_i` is 0; while it is 1 the line stays idle. A byte already launched completes unchanged if `peer_hold_i` rises during it.
- R4: While `cts_en` is 0, `peer_hold_i` has no effect on launching.
- R5: When receive storage is not full, `hold_off_o` is 0 if `rx_en` is 1 and 1 if `rx_en` is 0.
- R6: `hold_off_o` is 1 whenever receive storage is full, whatever the value of `rx_en`. Storage is one byte in direct mode (`fifo_en`=0) and four bytes in queue mode (`fifo_en`=1).
- R7: In direct mode, a received byte appears on `rd_data[7:0]` with `rd_data[15:8]` = 0. A one-cycle `rd_en` marks the holding register empty again.
- R8: In queue mode, up to four received bytes are kept in arrival order. `rd_data` shows the oldest, and each `rd_en` removes it. A byte that arrives while the queue is full is dropped.
- R9: In queue mode, writes are queued (up to four waiting) and sent in order, and a write to a full queue is dropped. In direct mode, a write made while a byte is pending or being sent is ignored.
- R10: A received frame whose stop bit samples low is discarded. It sets `frame_err`, which stays at 1 until reset.
- R11: Only `wr_data[7:0]` is transmitted; `wr_data[15:8]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Reception allowed (drives hold-off low when storage has room) |
| cts_en | input | 1 | Check the peer's hold-off before launching each byte |
| fifo_en | input | 1 | 1: four-byte queues; 0: direct holding registers |
| wr_en | input | 1 | Write strobe for the data port |
| wr_data | input | 16 | Write data; low byte transmitted |
| rd_en | input | 1 | Read acknowledge: pops the queue or frees the holding register |
| rd_data | output | 16 | Received byte in the low half, upper half zero |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| hold_off_o | output | 1 | High when this side cannot accept data |
| peer_hold_i | input | 1 | Peer's hold-off output |
| frame_err | output | 1 | Sticky flag for a bad stop bit |
| tx_active | output | 1 | A frame is on the line |

## Verification
A write reaches the line two rising edges after its strobe: one edge to store the byte, one to launch it. The bench therefore samples `txd` on the falling edges after each of those two edges. After that it finds the start of each frame by polling on falling edges and samples every bit at its midpoint, one full bit time apart. A received byte is stored a few cycles after the middle of its stop bit, so `hold_off_o`, `rd_data` and `frame_err` are checked only after the whole stop bit and two spare cycles have passed. Checks that something has no effect watch `txd` for several bit times and count any low sample as a failure.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_START = 2'd1,
    LN_DATA  = 2'd2,
    LN_STOP  = 2'd3
  } line_phase_e;

  // Hold-off level: busy when storage is full or reception is switched off.
  function automatic logic busy_level(input logic store_full, input logic rx_enable);
    return store_full | ~rx_enable;
  endfunction

  // Circular index advance for a queue of any depth.
  function automatic int next_index(input int idx, input int depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/uart_fc_queue.sv
module uart_fc_queue #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  import uart_fc_pkg::*;

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CNTW-1:0]  cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CNTW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp      <= AW'(next_index(int'(wp), DEPTH));
      end
      if (do_pop) rp <= AW'(next_index(int'(rp), DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8
  q_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(DEPTH));

  // R9
  q_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       avail,
  input  logic       permit,
  input  logic [7:0] din,
  output logic       take,
  output logic       txd,
  output logic       active
);
  import uart_fc_pkg::*;

  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  line_phase_e   phase;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          txd_q;
  logic          bit_end;

  assign bit_end = (cnt == LAST);
  assign take    = (phase == LN_IDLE) && avail && permit;
  assign txd     = txd_q;
  assign active  = (phase != LN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= LN_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      txd_q <= 1'b1;
    end else begin
      case (phase)
        LN_IDLE: begin
          if (take) begin
            sh    <= din;
            txd_q <= 1'b0;
            cnt   <= '0;
            phase <= LN_START;
          end
        end
        LN_START: begin
          if (bit_end) begin
            cnt   <= '0;
            bitn  <= '0;
            txd_q <= sh[0];
            phase <= LN_DATA;
          end else cnt <= cnt + 1'b1;
        end
        LN_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (bitn == 3'd7) begin
              txd_q <= 1'b1;
              phase <= LN_STOP;
            end else begin
              sh    <= {1'b0, sh[7:1]};
              txd_q <= sh[1];
              bitn  <= bitn + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (bit_end) begin
            cnt   <= '0;
            phase <= LN_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R2
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !txd);

  // R2
  tx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LN_STOP) |-> txd);

endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic       byte_ok,
  output logic       frame_bad,
  output logic [7:0] dout
);
  import uart_fc_pkg::*;

  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] LAST      = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);

  line_phase_e   phase;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          s1, s2, s3;
  logic          fall;
  logic          ok_q, bad_q;

  assign fall      = s3 && !s2;
  assign byte_ok   = ok_q;
  assign frame_bad = bad_q;
  assign dout      = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      s3    <= 1'b1;
      phase <= LN_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sh    <= '0;
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      s1    <= rxd;
      s2    <= s1;
      s3    <= s2;
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
      case (phase)
        LN_IDLE: begin
          if (fall) begin
            cnt   <= '0;
            phase <= LN_START;
          end
        end
        LN_START: begin
          if (cnt == HALF_LAST) begin
            cnt   <= '0;
            bitn  <= '0;
            phase <= s2 ? LN_IDLE : LN_DATA;
          end else cnt <= cnt + 1'b1;
        end
        LN_DATA: begin
          if (cnt == LAST) begin
            cnt <= '0;
            sh  <= {s2, sh[7:1]};
            if (bitn == 3'd7) phase <= LN_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            ok_q  <= s2;
            bad_q <= !s2;
            phase <= LN_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // R10
  rx_result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok_q, bad_q}));

  // R10
  rx_result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q || bad_q) |=> !(ok_q || bad_q));

endmodule

// File: rtl/uart_fc_core.sv
module uart_fc_core #(
  parameter int CLKS_PER_BIT = 8,
  parameter int QDEPTH       = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        cts_en,
  input  logic        fifo_en,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        txd,
  input  logic        rxd,
  output logic        hold_off_o,
  input  logic        peer_hold_i,
  output logic        frame_err,
  output logic        tx_active
);
  import uart_fc_pkg::*;

  localparam int BYTE_W = 8;

  // transmit side
  logic              permit, tx_take, tx_avail;
  logic [BYTE_W-1:0] tx_din, txq_dout, pend_byte;
  logic              pend_valid, txq_empty, txq_full_unused;
  wire               unused_upper = ^wr_data[15:8];

  assign permit   = !cts_en || !peer_hold_i;
  assign tx_avail = fifo_en ? !txq_empty : pend_valid;
  assign tx_din   = fifo_en ? txq_dout : pend_byte;

  uart_fc_queue #(.DEPTH(QDEPTH), .WIDTH(BYTE_W)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_en && fifo_en),
    .din   (wr_data[BYTE_W-1:0]),
    .pop   (tx_take && fifo_en),
    .dout  (txq_dout),
    .full  (txq_full_unused),
    .empty (txq_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_byte  <= '0;
      pend_valid <= 1'b0;
    end else if (!fifo_en && tx_take) begin
      pend_valid <= 1'b0;
    end else if (!fifo_en && wr_en && !pend_valid && !tx_active) begin
      pend_byte  <= wr_data[BYTE_W-1:0];
      pend_valid <= 1'b1;
    end
  end

  uart_fc_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .avail  (tx_avail),
    .permit (permit),
    .din    (tx_din),
    .take   (tx_take),
    .txd    (txd),
    .active (tx_active)
  );

  // receive side
  logic              rx_byte_ok, rx_frame_bad;
  logic [BYTE_W-1:0] rx_byte, rxq_dout, hold_byte;
  logic              hold_full, rxq_full, rxq_empty_unused, store_full;
  logic              ferr_q;

  uart_fc_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .byte_ok   (rx_byte_ok),
    .frame_bad (rx_frame_bad),
    .dout      (rx_byte)
  );

  uart_fc_queue #(.DEPTH(QDEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_byte_ok && fifo_en),
    .din   (rx_byte),
    .pop   (rd_en && fifo_en),
    .dout  (rxq_dout),
    .full  (rxq_full),
    .empty (rxq_empty_unused)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_byte <= '0;
      hold_full <= 1'b0;
      ferr_q    <= 1'b0;
    end else begin
      if (rx_frame_bad) ferr_q <= 1'b1;
      if (!fifo_en && rx_byte_ok && !hold_full) begin
        hold_byte <= rx_byte;
        hold_full <= 1'b1;
      end else if (!fifo_en && rd_en) begin
        hold_full <= 1'b0;
      end
    end
  end

  assign store_full = fifo_en ? rxq_full : hold_full;
  assign hold_off_o = busy_level(store_full, rx_en);
  assign rd_data    = {8'h00, (fifo_en ? rxq_dout : hold_byte)};
  assign frame_err  = ferr_q;

  // R3
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && cts_en) |-> !peer_hold_i);

  // R10
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R6
  full_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && hold_full) |-> hold_off_o);

endmodule

// File: tb/test_uart_fc_core.sv
module test_uart_fc_core;

  localparam int CPB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0, cts_en = 1'b0, fifo_en = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        txd, hold_off_o, frame_err, tx_active;
  logic        rxd = 1'b1, peer_hold_i = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  uart_fc_core #(.CLKS_PER_BIT(CPB), .QDEPTH(4)) i_uart_fc_core (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cts_en(cts_en), .fifo_en(fifo_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .txd(txd), .rxd(rxd), .hold_off_o(hold_off_o), .peer_hold_i(peer_hold_i),
    .frame_err(frame_err), .tx_active(tx_active)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    tick(1);
    wr_en   = 1'b0;
  endtask

  task automatic pulse_read();
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    rxd = 1'b0;
    tick(CPB);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      tick(CPB);
    end
    rxd = stop;
    tick(CPB);
    rxd = 1'b1;
    tick(2);
  endtask

  // Finds a start bit, samples each bit mid-way; optional hold rise mid-frame.
  task automatic capture(output logic [7:0] b, output bit good, input bit raise_hold);
    int w = 0;
    good = 1'b1;
    b = '0;
    while (txd !== 1'b0 && w < 3000) begin
      tick(1);
      w++;
    end
    if (w >= 3000) good = 1'b0;
    if (raise_hold) peer_hold_i = 1'b1;
    tick(CPB / 2 - 1);
    if (txd !== 1'b0) good = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(CPB);
      b[i] = txd;
    end
    tick(CPB);
    if (txd !== 1'b1) good = 1'b0;
  endtask

  task automatic expect_idle(input int n, input string req);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (txd !== 1'b1) lows++;
    end
    check(lows == 0, req, "txd low samples while idle expected", lows, 0);
  endtask

  task automatic t_reset();
    check(rd_data == 16'h0000, "R1", "rd_data after reset", rd_data, 0);
    check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    check(frame_err == 1'b0, "R1", "frame_err after reset", frame_err, 0);
    check(tx_active == 1'b0, "R1", "tx_active after reset", tx_active, 0);
    check(hold_off_o == 1'b1, "R5", "hold_off with rx_en=0", hold_off_o, 1);
  endtask

  task automatic t_direct_tx();
    logic [7:0] b;
    bit good;
    fifo_en = 1'b0;
    wr_data = 16'hA53C;
    wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
    check(txd == 1'b1, "R2", "txd one edge after write", txd, 1);
    tick(1);
    check(txd == 1'b0, "R2", "txd two edges after write", txd, 0);
    capture(b, good, 1'b0);
    check(good, "R2", "frame framing", good, 1);
    check(b == 8'h3C, "R11", "low byte only sent", b, 8'h3C);
    do_write(16'h00FF);  // tx still in stop bit: ignored
    expect_idle(3 * CPB, "R9");
  endtask

  task automatic t_cts();
    logic [7:0] b;
    bit good;
    cts_en = 1'b1;
    peer_hold_i = 1'b1;
    do_write(16'h0081);
    expect_idle(4 * CPB, "R3");
    peer_hold_i = 1'b0;
    capture(b, good, 1'b1);
    check(good && b == 8'h81, "R3", "byte completes after hold rise", b, 8'h81);
    peer_hold_i = 1'b0;
    cts_en = 1'b0;
    tick(CPB);
    peer_hold_i = 1'b1;
    do_write(16'h00C6);
    capture(b, good, 1'b0);
    check(good && b == 8'hC6, "R4", "hold ignored when cts_en=0", b, 8'hC6);
    peer_hold_i = 1'b0;
    tick(CPB);
  endtask

  task automatic t_queue_tx();
    logic [7:0] b;
    bit good;
    fifo_en = 1'b1;
    for (int i = 1; i <= 6; i++) do_write(16'(i * 17));
    for (int i = 1; i <= 5; i++) begin
      capture(b, good, 1'b0);
      check(good && b == 8'(i * 17), "R9", "queued byte order", b, i * 17);
    end
    expect_idle(3 * CPB, "R9");
    fifo_en = 1'b0;
  endtask

  task automatic t_direct_rx();
    fifo_en = 1'b0;
    rx_en = 1'b1;
    tick(1);
    check(hold_off_o == 1'b0, "R5", "hold_off with room, rx_en=1", hold_off_o, 0);
    send_rx(8'h5A, 1'b1);
    check(hold_off_o == 1'b1, "R6", "hold_off when holding full", hold_off_o, 1);
    check(rd_data == 16'h005A, "R7", "direct read data", rd_data, 16'h005A);
    pulse_read();
    check(hold_off_o == 1'b0, "R7", "hold_off after read", hold_off_o, 0);
    rx_en = 1'b0;
    tick(1);
    check(hold_off_o == 1'b1, "R5", "hold_off with rx_en=0", hold_off_o, 1);
    rx_en = 1'b1;
  endtask

  task automatic t_queue_rx();
    fifo_en = 1'b1;
    tick(1);
    for (int i = 0; i < 3; i++) send_rx(8'(8'hC1 + i), 1'b1);
    check(hold_off_o == 1'b0, "R8", "hold_off with 3 queued", hold_off_o, 0);
    send_rx(8'hC4, 1'b1);
    check(hold_off_o == 1'b1, "R6", "hold_off with 4 queued", hold_off_o, 1);
    send_rx(8'hC5, 1'b1);
    for (int i = 0; i < 4; i++) begin
      check(rd_data == 16'(16'h00C1 + i), "R8", "queue read order", rd_data, 16'h00C1 + i);
      pulse_read();
    end
    check(hold_off_o == 1'b0, "R8", "hold_off after drain", hold_off_o, 0);
    fifo_en = 1'b0;
  endtask

  task automatic t_frame_err();
    fifo_en = 1'b0;
    tick(1);
    send_rx(8'h77, 1'b0);
    check(frame_err == 1'b1, "R10", "frame_err after bad stop", frame_err, 1);
    check(hold_off_o == 1'b0, "R10", "bad byte not stored", hold_off_o, 0);
    send_rx(8'h42, 1'b1);
    check(rd_data == 16'h0042, "R10", "good byte after error", rd_data, 16'h0042);
    check(frame_err == 1'b1, "R10", "frame_err sticky", frame_err, 1);
    pulse_read();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_direct_tx();
    t_cts();
    t_queue_tx();
    t_direct_rx();
    t_queue_rx();
    t_frame_err();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule